// File: doc/BRIEF.md
# Program counter sequencer with paged loads and return stack

This block holds the program counter of a small microcontroller core and decides, once per clock, where execution goes next. It can step to the next instruction, load a jump or call target, take a computed address when software writes the low PC byte register, or return through a small hardware stack of saved addresses. The upper address bits do not come from the instruction. They come from a high-address latch register that lives in the register file. A computed load and a jump take different bits from that latch.

The surrounding core drives one strobe per operation, along with the target, the written byte and the latch value. The block updates the PC at the clock edge. It presents the low byte of the PC, together with a one-cycle pulse that tells the register file to refresh both bank copies of the low-byte register. Every operation completes in the cycle it is presented, so the strobes are plain control pins and have no handshake. The stack reports when it is full. It keeps a sticky flag once a return has been attempted on an empty stack.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the PC is 0, the stack is empty, `stack_full`, `stack_underflow` and `pcl_sync_we` are 0, and `pcl_byte` is 0.
- R2: A low-byte write loads the PC with the latch value (5 bits) in PC bits 12:8 and the written byte in bits 7:0.
- R3: A jump loads the PC with the 11-bit target in bits 10:0 and latch bits 4:3 in PC bits 12:11.
- R4: A call saves PC+1 (modulo 2^13) on the stack and then loads the PC exactly as a jump does.
- R5: A return on a non-empty stack loads the PC with the most recently saved entry and removes it, in last-in first-out order.
- R6: A return on an empty stack leaves the PC unchanged and sets `stack_underflow`, which stays set until reset.
- R7: An increment adds 1 to the PC modulo 2^13, except when the PC equals 0x3FF, in which case the PC holds.
- R8: The stack holds 8 entries and `stack_full` is 1 exactly when it holds 8. A call while full still loads the target, but saves nothing.
- R9: One operation takes effect per clock, chosen in the order low-byte write, call, jump, return, increment. With no strobe the PC holds.
- R10: `pcl_byte` always equals PC bits 7:0. `pcl_sync_we` is 1 in the cycle after any edge at which the PC changed value, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcl_wr_en | input | 1 | Software write to the low PC byte register |
| pcl_wr_data | input | 8 | Byte written to the low PC byte register |
| jump_en | input | 1 | Jump strobe |
| call_en | input | 1 | Call strobe |
| ret_en | input | 1 | Return strobe |
| inc_en | input | 1 | Step strobe |
| jump_target | input | 11 | Jump or call target from the instruction |
| pclath | input | 5 | High-address latch value from the register file |
| pc | output | 13 | Current program counter |
| pcl_byte | output | 8 | Low PC byte for the register file's low-byte copies |
| pcl_sync_we | output | 1 | Refresh pulse for both bank copies of the low byte |
| stack_full | output | 1 | Return stack holds its maximum number of entries |
| stack_underflow | output | 1 | Sticky flag: return attempted on an empty stack |

## Verification
The bench builds the block with its defaults: a 13-bit PC, 11-bit targets, an 8-entry stack and a step limit of 0x3FF. With an 11-bit target a single jump lands exactly on the 0x3FF hold point, and eight calls reach a full stack within a few cycles. A low-byte write can reach the top page, so the wrap from 0x1FFF to 0 is also within reach. Random streams of overlapping strobes then exercise the priority order and the page selection against a reference model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_PCLW,
    OP_CALL,
    OP_JUMP,
    OP_RET,
    OP_INC
  } pc_op_e;
endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
  import pcseq_pkg::*;
(
  input  logic   pcl_wr_en,
  input  logic   jump_en,
  input  logic   call_en,
  input  logic   ret_en,
  input  logic   inc_en,
  output pc_op_e op
);
  // fixed priority: computed write, call, jump, return, step
  always_comb begin
    if (pcl_wr_en)    op = OP_PCLW;
    else if (call_en) op = OP_CALL;
    else if (jump_en) op = OP_JUMP;
    else if (ret_en)  op = OP_RET;
    else if (inc_en)  op = OP_INC;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/pcseq_retstack.sv
module pcseq_retstack #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_en,
  input  logic [PC_W-1:0] push_data,
  input  logic            pop_en,
  output logic [PC_W-1:0] top_data,
  output logic            empty,
  output logic            full
);
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] cnt_q;
  logic [PC_W-1:0]  slot_q [DEPTH];
  logic             do_push;
  logic             do_pop;

  assign full    = (cnt_q == PTR_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_en && !full;
  assign do_pop  = pop_en && !empty && !push_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (do_push) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (do_pop) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_push && (cnt_q == PTR_W'(i))) slot_q[i] <= push_data;
      end
    end
  end

  always_comb begin
    top_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == PTR_W'(i + 1)) top_data = slot_q[i];
    end
  end
endmodule

// File: rtl/pcseq_nextpc.sv
module pcseq_nextpc
  import pcseq_pkg::*;
#(
  parameter int          PC_W     = 13,
  parameter int          TGT_W    = 11,
  parameter int unsigned INC_STOP = 'h3FF
) (
  input  pc_op_e             op,
  input  logic [PC_W-1:0]    pc,
  input  logic [PC_W-9:0]    pclath,
  input  logic [7:0]         pcl_data,
  input  logic [TGT_W-1:0]   target,
  input  logic [PC_W-1:0]    stack_top,
  input  logic               stack_empty,
  output logic [PC_W-1:0]    pc_next,
  output logic [PC_W-1:0]    link_pc,
  output logic               push_en,
  output logic               pop_en,
  output logic               underflow_set
);
  localparam int PAGE_W   = PC_W - TGT_W;
  localparam int PAGE_LSB = TGT_W - 8;

  logic [PC_W-1:0] jump_pc;
  logic [PC_W-1:0] pclw_pc;

  assign jump_pc = {pclath[PAGE_LSB +: PAGE_W], target};
  assign pclw_pc = {pclath, pcl_data};
  assign link_pc = pc + 1'b1;

  always_comb begin
    pc_next       = pc;
    push_en       = 1'b0;
    pop_en        = 1'b0;
    underflow_set = 1'b0;
    unique case (op)
      OP_PCLW: pc_next = pclw_pc;
      OP_CALL: begin
        pc_next = jump_pc;
        push_en = 1'b1;
      end
      OP_JUMP: pc_next = jump_pc;
      OP_RET: begin
        if (stack_empty) begin
          underflow_set = 1'b1;
        end else begin
          pc_next = stack_top;
          pop_en  = 1'b1;
        end
      end
      OP_INC:  pc_next = (pc == PC_W'(INC_STOP)) ? pc : link_pc;
      default: pc_next = pc;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int          PC_W     = 13,
  parameter int          TGT_W    = 11,
  parameter int          DEPTH    = 8,
  parameter int unsigned INC_STOP = 'h3FF,
  localparam int         HI_W     = PC_W - 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcl_wr_en,
  input  logic [7:0]       pcl_wr_data,
  input  logic             jump_en,
  input  logic             call_en,
  input  logic             ret_en,
  input  logic             inc_en,
  input  logic [TGT_W-1:0] jump_target,
  input  logic [HI_W-1:0]  pclath,
  output logic [PC_W-1:0]  pc,
  output logic [7:0]       pcl_byte,
  output logic             pcl_sync_we,
  output logic             stack_full,
  output logic             stack_underflow
);
  pc_op_e          op;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_next;
  logic [PC_W-1:0] link_pc;
  logic [PC_W-1:0] stack_top;
  logic            stack_empty;
  logic            push_en;
  logic            pop_en;
  logic            underflow_set;
  logic            uf_q;
  logic            sync_q;

  pcseq_arbiter u_arb (
    .pcl_wr_en (pcl_wr_en),
    .jump_en   (jump_en),
    .call_en   (call_en),
    .ret_en    (ret_en),
    .inc_en    (inc_en),
    .op        (op)
  );

  pcseq_nextpc #(
    .PC_W     (PC_W),
    .TGT_W    (TGT_W),
    .INC_STOP (INC_STOP)
  ) u_next (
    .op            (op),
    .pc            (pc_q),
    .pclath        (pclath),
    .pcl_data      (pcl_wr_data),
    .target        (jump_target),
    .stack_top     (stack_top),
    .stack_empty   (stack_empty),
    .pc_next       (pc_next),
    .link_pc       (link_pc),
    .push_en       (push_en),
    .pop_en        (pop_en),
    .underflow_set (underflow_set)
  );

  pcseq_retstack #(
    .PC_W  (PC_W),
    .DEPTH (DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_data (link_pc),
    .pop_en    (pop_en),
    .top_data  (stack_top),
    .empty     (stack_empty),
    .full      (stack_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      uf_q   <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      pc_q   <= pc_next;
      sync_q <= (pc_next != pc_q);
      if (underflow_set) uf_q <= 1'b1;
    end
  end

  assign pc              = pc_q;
  assign pcl_byte        = pc_q[7:0];
  assign pcl_sync_we     = sync_q;
  assign stack_underflow = uf_q;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int          PC_W     = 13,
  parameter int          TGT_W    = 11,
  parameter int unsigned INC_STOP = 'h3FF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pcl_wr_en,
  input logic [7:0]       pcl_wr_data,
  input logic             jump_en,
  input logic             call_en,
  input logic             ret_en,
  input logic             inc_en,
  input logic [TGT_W-1:0] jump_target,
  input logic [PC_W-9:0]  pclath,
  input logic [PC_W-1:0]  pc,
  input logic             pcl_sync_we,
  input logic             stack_full,
  input logic             stack_underflow
);
  localparam int PAGE_W   = PC_W - TGT_W;
  localparam int PAGE_LSB = TGT_W - 8;

  // R2: computed load places latch above the written byte
  p_pcl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pcl_wr_en |=> (pc == {$past(pclath), $past(pcl_wr_data)}));

  // R3 and R4: jump or call takes target and two latch page bits
  p_jump_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcl_wr_en && (jump_en || call_en)) |=>
      (pc == {$past(pclath[PAGE_LSB +: PAGE_W]), $past(jump_target)}));

  // R6: underflow flag is sticky
  p_uf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stack_underflow |=> stack_underflow);

  // R7: step holds at the stop value
  p_inc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcl_wr_en && !jump_en && !call_en && !ret_en && inc_en &&
     (pc == PC_W'(INC_STOP))) |=> $stable(pc));

  // R8: call on a full stack leaves it full
  p_full_call_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_full && !pcl_wr_en && call_en) |=> stack_full);

  // R9: no strobe, no movement
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcl_wr_en && !jump_en && !call_en && !ret_en && !inc_en) |=> $stable(pc));

  // R10: refresh pulse marks exactly the PC changes
  p_sync_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pcl_sync_we == (pc != $past(pc)));
endmodule

bind pc_sequencer pcseq_checker #(
  .PC_W     (PC_W),
  .TGT_W    (TGT_W),
  .INC_STOP (INC_STOP)
) u_pcseq_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .pcl_wr_en       (pcl_wr_en),
  .pcl_wr_data     (pcl_wr_data),
  .jump_en         (jump_en),
  .call_en         (call_en),
  .ret_en          (ret_en),
  .inc_en          (inc_en),
  .jump_target     (jump_target),
  .pclath          (pclath),
  .pc              (pc),
  .pcl_sync_we     (pcl_sync_we),
  .stack_full      (stack_full),
  .stack_underflow (stack_underflow)
);

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        pcl_wr_en = 1'b0;
  logic [7:0]  pcl_wr_data = '0;
  logic        jump_en = 1'b0;
  logic        call_en = 1'b0;
  logic        ret_en = 1'b0;
  logic        inc_en = 1'b0;
  logic [10:0] jump_target = '0;
  logic [4:0]  pclath = '0;
  logic [12:0] pc;
  logic [7:0]  pcl_byte;
  logic        pcl_sync_we;
  logic        stack_full;
  logic        stack_underflow;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  int          m_cnt;
  bit          m_uf;
  bit          m_sync;

  always #5 clk = ~clk;

  pc_sequencer dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .pcl_wr_en       (pcl_wr_en),
    .pcl_wr_data     (pcl_wr_data),
    .jump_en         (jump_en),
    .call_en         (call_en),
    .ret_en          (ret_en),
    .inc_en          (inc_en),
    .jump_target     (jump_target),
    .pclath          (pclath),
    .pc              (pc),
    .pcl_byte        (pcl_byte),
    .pcl_sync_we     (pcl_sync_we),
    .stack_full      (stack_full),
    .stack_underflow (stack_underflow)
  );

  function automatic logic [12:0] f_pclw(logic [4:0] lath, logic [7:0] d);
    return {lath, d};
  endfunction

  function automatic logic [12:0] f_jump(logic [4:0] lath, logic [10:0] t);
    return {lath[4:3], t};
  endfunction

  function automatic logic [12:0] f_inc(logic [12:0] p);
    return (p == 13'h3FF) ? p : p + 13'd1;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "pc", 32'(pc), 32'(m_pc));
    chk("R10", "pcl_byte", 32'(pcl_byte), 32'(m_pc[7:0]));
    chk("R10", "pcl_sync_we", 32'(pcl_sync_we), 32'(m_sync));
    chk("R8", "stack_full", 32'(stack_full), 32'(m_cnt == 8));
    chk("R6", "stack_underflow", 32'(stack_underflow), 32'(m_uf));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pcl_wr_en = 0; jump_en = 0; call_en = 0; ret_en = 0; inc_en = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0; m_cnt = 0; m_uf = 0; m_sync = 0;
    check_all("R1");
  endtask

  task automatic step(bit pw, logic [7:0] pd, bit j, bit c, bit r, bit i,
                      logic [10:0] tgt, logic [4:0] lath, string tag);
    logic [12:0] old;
    string t;
    pcl_wr_en = pw; pcl_wr_data = pd; jump_en = j; call_en = c;
    ret_en = r; inc_en = i; jump_target = tgt; pclath = lath;
    old = m_pc;
    if (pw) begin
      t = "R2"; m_pc = f_pclw(lath, pd);
    end else if (c || j) begin
      t = c ? "R4" : "R3";
      if (c && m_cnt < 8) begin m_stk[m_cnt] = m_pc + 13'd1; m_cnt++; end
      m_pc = f_jump(lath, tgt);
    end else if (r) begin
      if (m_cnt == 0) begin t = "R6"; m_uf = 1; end
      else begin t = "R5"; m_cnt--; m_pc = m_stk[m_cnt]; end
    end else if (i) begin
      t = "R7"; m_pc = f_inc(m_pc);
    end else begin
      t = "R9";
    end
    m_sync = (m_pc != old);
    @(posedge clk);
    @(negedge clk);
    pcl_wr_en = 0; jump_en = 0; call_en = 0; ret_en = 0; inc_en = 0;
    check_all(tag == "" ? t : tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240502));
    #2;
    do_reset();                                              // R1

    step(1, 8'h5C, 0, 0, 0, 0, 11'h0, 5'h1A, "R2");         // 0x1A5C
    step(0, 8'h00, 1, 0, 0, 0, 11'h123, 5'b10110, "R3");    // 0x1123
    step(0, 8'h00, 0, 0, 0, 0, 11'h0, 5'h1F, "R9");         // idle hold
    step(0, 8'h00, 1, 0, 0, 0, 11'h3FF, 5'h00, "R3");       // 0x3FF
    step(0, 8'h00, 0, 0, 0, 1, 11'h0, 5'h00, "R7");         // holds at 0x3FF
    step(1, 8'hFF, 0, 0, 0, 0, 11'h0, 5'h1F, "R2");         // 0x1FFF
    step(0, 8'h00, 0, 0, 0, 1, 11'h0, 5'h00, "R7");         // wraps to 0
    step(0, 8'h00, 0, 0, 0, 1, 11'h0, 5'h00, "R7");         // 1

    // fill stack beyond capacity: R4, R8
    for (int k = 0; k < 9; k++)
      step(0, 8'h00, 0, 1, 0, 0, 11'(16 * k + 3), 5'(k * 8), "R8");
    // drain in LIFO order, then one extra return: R5, R6
    for (int k = 0; k < 8; k++)
      step(0, 8'h00, 0, 0, 1, 0, 11'h0, 5'h0, "R5");
    step(0, 8'h00, 0, 0, 1, 0, 11'h0, 5'h0, "R6");
    step(0, 8'h00, 0, 0, 0, 1, 11'h0, 5'h0, "R6");

    // priority corners: R9
    step(1, 8'hA7, 1, 1, 1, 1, 11'h555, 5'h0B, "R9");
    step(0, 8'h00, 1, 1, 1, 1, 11'h2AA, 5'h18, "R9");
    step(0, 8'h00, 1, 0, 1, 1, 11'h0F0, 5'h08, "R9");
    step(0, 8'h00, 0, 0, 1, 1, 11'h0, 5'h0, "R9");

    do_reset();                                              // R1 again

    for (int n = 0; n < 4000; n++) begin
      logic [10:0] tg;
      tg = ($urandom_range(0, 3) == 0) ? 11'(12'h3FE + $urandom_range(0, 1))
                                       : 11'($urandom);
      step($urandom_range(0, 99) < 6, 8'($urandom),
           $urandom_range(0, 99) < 10, $urandom_range(0, 99) < 12,
           $urandom_range(0, 99) < 16, $urandom_range(0, 99) < 60,
           tg, 5'($urandom), "");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule